// File: doc/BRIEF.md
# Cascadable Column Data Sampler

This block is the digital front end of one column driver in a chain of display drivers. On every rising edge of the shift clock it takes one 18-bit word. The word holds three 6-bit gray codes, one for each colour dot. A slot pointer steers the word into a wide column data register. The pointer starts when a start pulse arrives on the input side of a bidirectional start-pulse pair. When the last slot has been written, the block sends a one-cycle start pulse out of the other side of the pair, and that pulse starts the next driver in the chain. An inversion input can complement the data as it is stored. A rising edge on the strobe copies the whole data register into an output latch and sends the pointer back to idle. The latch drives one 6-bit code per column.

The pointer runs in a finite-state machine with three states:
- `ST_UNARMED`: the state after reset. Start pulses are ignored.
- `ST_IDLE`: armed and waiting for a start pulse.
- `ST_FILL`: writing one slot per clock.

The transitions are:
- *arm*: `ST_UNARMED` to `ST_IDLE` on the first strobe.
- *launch*: `ST_IDLE` to `ST_FILL` on a start pulse.
- *advance*: `ST_FILL` to `ST_FILL`, writing a slot and stepping the pointer.
- *restart*: `ST_FILL` to `ST_FILL` on a fresh start pulse.
- *finish*: `ST_FILL` to `ST_IDLE` after the last slot, which raises the cascade pulse.
- *abort*: `ST_FILL` to `ST_IDLE` on a strobe.

The fill direction and the column mode are captured at launch or restart. Slot `s` holds the zero-based columns 3s, 3s+1 and 3s+2.

Top module: `colsamp_top`

## Requirements
- R1: After reset, `col_o` is all zero and both cascade outputs are low. Start pulses are ignored until the first rising edge of `stb_i`.
- R2: When `dir_i` is high, the start pulse is read from `spr_i`, `spl_oe` is high, `spr_oe` is low, and the cascade pulse appears on `spl_o`. When `dir_i` is low, these roles are swapped, and a pulse on `spr_i` starts nothing.
- R3: The edge that samples a start pulse writes no data. Each following edge writes one slot. In slot `s`, `data_i[5:0]` goes to column 3s, `data_i[11:6]` goes to column 3s+1 and `data_i[17:12]` goes to column 3s+2. Column `c` sits at `col_o[6c+5:6c]`. With `dir_i` high the slots are filled in the order 0 up to 133; with `dir_i` low they are filled from 133 down to 0.
- R4: When `inv_i` is high in a write cycle, every stored bit is the complement of the input bit. When `inv_i` is low, the data is stored unchanged.
- R5: In full mode (`full_i` high), the cascade output is high for exactly one cycle. It rises on the edge that writes the last slot, which is the 134th clock after the edge that sampled the start pulse.
- R6: When `full_i` is low at launch, slots 64 to 69 (columns 192 to 209) are skipped and keep their contents. The cascade pulse then comes on the 128th clock.
- R7: After the last slot is written, further clocks change nothing until the next start pulse.
- R8: A start pulse during a fill restarts the fill from the first slot, and the full count to the cascade pulse begins again.
- R9: On the edge where `stb_i` is high and was low on the previous edge, `col_o` takes the contents of the data register. On every other edge, `col_o` holds its value.
- R10: A strobe stops a fill in progress. No further slot is written and no cascade pulse is sent. A strobe takes precedence over a start pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Fill direction: 1 = ascending slots, 0 = descending slots |
| full_i | input | 1 | Column mode: 1 = all 402 columns, 0 = 384 columns |
| inv_i | input | 1 | Complement the data while it is stored |
| data_i | input | 18 | Three 6-bit dot codes |
| stb_i | input | 1 | Strobe: latch the data register and clear the pointer |
| spr_i | input | 1 | Right start-pulse pin, input side |
| spl_i | input | 1 | Left start-pulse pin, input side |
| spr_o | output | 1 | Right start-pulse pin, output side |
| spl_o | output | 1 | Left start-pulse pin, output side |
| spr_oe | output | 1 | Output enable of the right start-pulse pin |
| spl_oe | output | 1 | Output enable of the left start-pulse pin |
| col_o | output | 2412 | Latched 6-bit code for each column |

## Verification
The assertions assume the following about the inputs:
- `dir_i` does not change while a cascade pulse is on the pins, so the pulse stays on the enabled side.
- The strobe is a clean level that the shift clock samples, so its edge is the change seen from one clock to the next.
- The start pulse lasts exactly one clock.

The stimulus keeps to these assumptions. It holds the direction and mode fixed through each fill. It raises each strobe and each start pulse for a single clock. It changes inputs only just after a clock edge.

// File: rtl/colsamp_pkg.sv
package colsamp_pkg;
    typedef enum logic [1:0] {
        ST_UNARMED = 2'd0,
        ST_IDLE    = 2'd1,
        ST_FILL    = 2'd2
    } ptr_state_t;
endpackage

// File: rtl/colsamp_ptr.sv
module colsamp_ptr
    import colsamp_pkg::*;
#(
    parameter int SLOTS      = 134,
    parameter int SKIP_FIRST = 64,
    parameter int SKIP_SLOTS = 6,
    parameter int SW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stb_rise_i,
    input  logic          dir_i,
    input  logic          full_i,
    output logic          wr_en_o,
    output logic [SW-1:0] wr_slot_o,
    output logic          casc_o,
    output logic          full_q_o
);
    localparam logic [SW-1:0] LAST_SLOT  = SW'(SLOTS - 1);
    localparam logic [SW-1:0] BAND_BELOW = SW'(SKIP_FIRST - 1);
    localparam logic [SW-1:0] BAND_ABOVE = SW'(SKIP_FIRST + SKIP_SLOTS);

    ptr_state_t    state, state_n;
    logic [SW-1:0] ptr, ptr_n;
    logic          dir_q, dir_n;
    logic          full_q, full_n;
    logic          casc_q, casc_n;
    logic [SW-1:0] end_slot;
    logic [SW-1:0] step_slot;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_UNARMED;
            ptr    <= '0;
            dir_q  <= 1'b1;
            full_q <= 1'b1;
            casc_q <= 1'b0;
        end else begin
            state  <= state_n;
            ptr    <= ptr_n;
            dir_q  <= dir_n;
            full_q <= full_n;
            casc_q <= casc_n;
        end
    end

    always_comb begin
        end_slot = dir_q ? LAST_SLOT : '0;
        if (dir_q) begin
            if (!full_q && ptr == BAND_BELOW) step_slot = BAND_ABOVE;
            else                              step_slot = ptr + 1'b1;
        end else begin
            if (!full_q && ptr == BAND_ABOVE) step_slot = BAND_BELOW;
            else                              step_slot = ptr - 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        ptr_n   = ptr;
        dir_n   = dir_q;
        full_n  = full_q;
        casc_n  = 1'b0;
        unique case (state)
            ST_UNARMED: begin
                if (stb_rise_i) state_n = ST_IDLE;          // arm
            end
            ST_IDLE: begin
                if (!stb_rise_i && start_i) begin           // launch
                    state_n = ST_FILL;
                    ptr_n   = dir_i ? '0 : LAST_SLOT;
                    dir_n   = dir_i;
                    full_n  = full_i;
                end
            end
            ST_FILL: begin
                if (stb_rise_i) begin                        // abort
                    state_n = ST_IDLE;
                end else if (start_i) begin                  // restart
                    ptr_n  = dir_i ? '0 : LAST_SLOT;
                    dir_n  = dir_i;
                    full_n = full_i;
                end else if (ptr == end_slot) begin          // finish
                    state_n = ST_IDLE;
                    casc_n  = 1'b1;
                end else begin                               // advance
                    ptr_n = step_slot;
                end
            end
            default: state_n = ST_UNARMED;
        endcase
    end

    // outputs
    always_comb begin
        wr_en_o   = (state == ST_FILL) && !stb_rise_i && !start_i;
        wr_slot_o = ptr;
        casc_o    = casc_q;
        full_q_o  = full_q;
    end
endmodule

// File: rtl/colsamp_dreg.sv
module colsamp_dreg #(
    parameter int SLOTS = 134,
    parameter int DOTS  = 3,
    parameter int CW    = 6,
    parameter int SW    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [SW-1:0]               wr_slot_i,
    input  logic                        inv_i,
    input  logic [DOTS*CW-1:0]          data_i,
    output logic [SLOTS*DOTS*CW-1:0]    dreg_o
);
    localparam int DW = DOTS * CW;

    logic [DW-1:0] word;
    assign word = inv_i ? ~data_i : data_i;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [DW-1:0] seg_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   seg_q <= '0;
            else if (wr_en_i && wr_slot_i == SW'(s))      seg_q <= word;
        end
        assign dreg_o[s*DW +: DW] = seg_q;
    end
endmodule

// File: rtl/colsamp_olat.sv
module colsamp_olat #(
    parameter int W = 2412
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end
endmodule

// File: rtl/colsamp_top.sv
module colsamp_top #(
    parameter int SLOTS      = 134,
    parameter int DOTS       = 3,
    parameter int CW         = 6,
    parameter int SKIP_FIRST = 64,
    parameter int SKIP_SLOTS = 6,
    localparam int COLS      = SLOTS * DOTS,
    localparam int DW        = DOTS * CW,
    localparam int SW        = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dir_i,
    input  logic               full_i,
    input  logic               inv_i,
    input  logic [DW-1:0]      data_i,
    input  logic               stb_i,
    input  logic               spr_i,
    input  logic               spl_i,
    output logic               spr_o,
    output logic               spl_o,
    output logic               spr_oe,
    output logic               spl_oe,
    output logic [COLS*CW-1:0] col_o
);
    logic          stb_q;
    logic          stb_rise;
    logic          start;
    logic          wr_en;
    logic [SW-1:0] wr_slot;
    logic          casc;
    logic          full_q;
    logic [COLS*CW-1:0] dreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= stb_i;
    end

    assign stb_rise = stb_i && !stb_q;
    assign start    = dir_i ? spr_i : spl_i;
    assign spl_oe   = dir_i;
    assign spr_oe   = !dir_i;
    assign spl_o    = casc && dir_i;
    assign spr_o    = casc && !dir_i;

    colsamp_ptr #(
        .SLOTS(SLOTS), .SKIP_FIRST(SKIP_FIRST), .SKIP_SLOTS(SKIP_SLOTS), .SW(SW)
    ) ptr_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .stb_rise_i(stb_rise),
        .dir_i(dir_i), .full_i(full_i), .wr_en_o(wr_en), .wr_slot_o(wr_slot),
        .casc_o(casc), .full_q_o(full_q)
    );

    colsamp_dreg #(
        .SLOTS(SLOTS), .DOTS(DOTS), .CW(CW), .SW(SW)
    ) dreg_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_slot_i(wr_slot),
        .inv_i(inv_i), .data_i(data_i), .dreg_o(dreg)
    );

    colsamp_olat #(
        .W(COLS*CW)
    ) olat_i (
        .clk(clk), .rst_n(rst_n), .load_i(stb_rise), .d_i(dreg), .q_o(col_o)
    );
endmodule

// File: rtl/colsamp_chk.sv
module colsamp_chk #(
    parameter int SW         = 8,
    parameter int W          = 2412,
    parameter int SKIP_FIRST = 64,
    parameter int SKIP_SLOTS = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stb_i,
    input logic          wr_en,
    input logic [SW-1:0] wr_slot,
    input logic          full_q,
    input logic          casc,
    input logic          spl_o,
    input logic          spr_o,
    input logic          spl_oe,
    input logic          spr_oe,
    input logic [W-1:0]  col_o
);
    logic stb_prev;
    logic armed;
    logic rise_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_prev <= 1'b0;
            armed    <= 1'b0;
        end else begin
            stb_prev <= stb_i;
            if (stb_i && !stb_prev) armed <= 1'b1;
        end
    end
    assign rise_c = stb_i && !stb_prev;

    // R1
    unarmed_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !wr_en);
    // R2
    left_pulse_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spl_o |-> spl_oe);
    // R2
    right_pulse_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spr_o |-> spr_oe);
    // R5
    casc_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        casc |=> !casc);
    // R5
    casc_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        casc |-> $past(wr_en));
    // R6
    skip_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full_q) |->
            (int'(wr_slot) < SKIP_FIRST || int'(wr_slot) >= SKIP_FIRST + SKIP_SLOTS));
    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rise_c) |-> $stable(col_o));
    // R10
    strobe_kills_casc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_c |=> !casc);
endmodule

bind colsamp_top colsamp_chk #(
    .SW(SW), .W(COLS*CW), .SKIP_FIRST(SKIP_FIRST), .SKIP_SLOTS(SKIP_SLOTS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .stb_i(stb_i), .wr_en(wr_en), .wr_slot(wr_slot),
    .full_q(full_q), .casc(casc), .spl_o(spl_o), .spr_o(spr_o),
    .spl_oe(spl_oe), .spr_oe(spr_oe), .col_o(col_o)
);

// File: tb/colsamp_top_tb.sv
module colsamp_top_tb_top;
    localparam int SLOTS = 134;
    localparam int DOTS  = 3;
    localparam int CW    = 6;
    localparam int COLS  = SLOTS * DOTS;
    localparam int DW    = DOTS * CW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               dir_i = 1'b1, full_i = 1'b1, inv_i = 1'b0;
    logic [DW-1:0]      data_i = '0;
    logic               stb_i = 1'b0, spr_i = 1'b0, spl_i = 1'b0;
    logic               spr_o, spl_o, spr_oe, spl_oe;
    logic [COLS*CW-1:0] col_o;

    colsamp_top dut_i (
        .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .full_i(full_i), .inv_i(inv_i),
        .data_i(data_i), .stb_i(stb_i), .spr_i(spr_i), .spl_i(spl_i),
        .spr_o(spr_o), .spl_o(spl_o), .spr_oe(spr_oe), .spl_oe(spl_oe),
        .col_o(col_o)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    // behavioural reference
    int m_dreg[COLS];
    int m_lat[COLS];
    bit m_armed, m_active, m_dirq, m_fullq, m_casc, m_stbp;
    int m_ptr;
    bit casc_seen, any_casc;
    logic [31:0] lcg = 32'h1234_5678;

    task automatic check_int(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bool_skip(int s);
        return (!m_fullq && s >= 64 && s <= 69);
    endfunction

    function automatic void model_edge();
        bit rise, start;
        if (!rst_n) begin
            foreach (m_dreg[c]) begin m_dreg[c] = 0; m_lat[c] = 0; end
            m_armed = 0; m_active = 0; m_casc = 0; m_stbp = 0; m_ptr = 0;
            m_dirq = 1; m_fullq = 1;
            return;
        end
        rise   = stb_i && !m_stbp;
        m_stbp = stb_i;
        start  = dir_i ? spr_i : spl_i;
        m_casc = 0;
        if (rise) begin
            foreach (m_lat[c]) m_lat[c] = m_dreg[c];
            m_armed  = 1;
            m_active = 0;
        end else if (m_armed && start) begin
            m_active = 1;
            m_dirq   = dir_i;
            m_fullq  = full_i;
            m_ptr    = dir_i ? 0 : SLOTS - 1;
        end else if (m_active) begin
            for (int d = 0; d < DOTS; d++) begin
                int v = (data_i >> (d * CW)) & 63;
                m_dreg[m_ptr * DOTS + d] = inv_i ? (~v) & 63 : v;
            end
            if (m_ptr == (m_dirq ? SLOTS - 1 : 0)) begin
                m_active = 0;
                m_casc   = 1;
            end else begin
                do m_ptr = m_dirq ? m_ptr + 1 : m_ptr - 1;
                while (bool_skip(m_ptr));
            end
        end
    endfunction

    task automatic cols(string tag);
        int bad_c = -1;
        for (int c = 0; c < COLS; c++)
            if (bad_c < 0 && int'(col_o[c*CW +: CW]) != m_lat[c]) bad_c = c;
        if (bad_c < 0) check_int(tag, "columns", 0, 0);
        else check_int(tag, $sformatf("column %0d", bad_c),
                       int'(col_o[bad_c*CW +: CW]), m_lat[bad_c]);
    endtask

    task automatic tick();
        int exp_pins;
        @(posedge clk);
        model_edge();
        #1;
        exp_pins = m_casc ? (dir_i ? 1 : 2) : 0;
        // R2 output enables follow the direction input
        check_int("R2", "oe", int'({spr_oe, spl_oe}), dir_i ? 1 : 2);
        // R5 cascade pins {spr_o,spl_o}
        check_int("R5", "cascade", int'({spr_o, spl_o}), exp_pins);
        // R9 latched columns every clock
        cols("R9");
        casc_seen = spr_o | spl_o;
        if (casc_seen) any_casc = 1;
    endtask

    task automatic rand_data();
        lcg    = lcg * 32'd1103515245 + 32'd12345;
        data_i = lcg[29:12];
    endtask

    task automatic fill(bit d, bit f, bit iv, int exp_len, string tag);
        int cnt = 0;
        dir_i = d; full_i = f; inv_i = iv;
        if (d) spr_i = 1'b1; else spl_i = 1'b1;
        rand_data();
        tick();
        spr_i = 1'b0; spl_i = 1'b0;
        casc_seen = 0;
        while (!casc_seen && cnt < 200) begin
            rand_data();
            tick();
            cnt++;
        end
        check_int(tag, "clocks to cascade", cnt, exp_len);
    endtask

    task automatic strobe(string tag);
        stb_i = 1'b1;
        tick();
        stb_i = 1'b0;
        tick();
        cols(tag);
    endtask

    task automatic idle_clocks(int n);
        for (int i = 0; i < n; i++) begin rand_data(); tick(); end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check_int("R1", "col_o nonzero", int'(col_o != '0), 0);
        check_int("R1", "cascade pins", int'({spr_o, spl_o}), 0);

        // R1 start before the first strobe is ignored
        any_casc = 0;
        dir_i = 1'b1; spr_i = 1'b1; tick(); spr_i = 1'b0;
        idle_clocks(140);
        check_int("R1", "cascade before arm", int'(any_casc), 0);
        strobe("R1");
        check_int("R1", "col_o after arming", int'(col_o != '0), 0);

        // R3 ascending full fill
        fill(1'b1, 1'b1, 1'b0, 134, "R5");
        strobe("R3");
        // R4 descending with inversion
        fill(1'b0, 1'b1, 1'b1, 134, "R4");
        strobe("R4");
        // R6 reduced mode both directions
        fill(1'b1, 1'b0, 1'b0, 128, "R6");
        strobe("R6");
        fill(1'b0, 1'b0, 1'b1, 128, "R6");
        strobe("R6");

        // R7 clocks after completion change nothing
        fill(1'b1, 1'b1, 1'b1, 134, "R5");
        any_casc = 0;
        idle_clocks(30);
        check_int("R7", "extra cascade", int'(any_casc), 0);
        strobe("R7");

        // R8 restart mid-fill
        dir_i = 1'b1; full_i = 1'b1; spr_i = 1'b1; tick(); spr_i = 1'b0;
        idle_clocks(50);
        fill(1'b1, 1'b1, 1'b0, 134, "R8");
        strobe("R8");

        // R2 pulse on the output-side pin does not launch
        any_casc = 0;
        dir_i = 1'b0; spr_i = 1'b1; tick(); spr_i = 1'b0;
        idle_clocks(140);
        check_int("R2", "launch from wrong pin", int'(any_casc), 0);

        // R10 strobe aborts a fill
        any_casc = 0;
        dir_i = 1'b0; spl_i = 1'b1; tick(); spl_i = 1'b0;
        idle_clocks(30);
        strobe("R10");
        idle_clocks(140);
        check_int("R10", "cascade after abort", int'(any_casc), 0);
        // R10 strobe wins over a start in the same cycle
        any_casc = 0;
        dir_i = 1'b1; stb_i = 1'b1; spr_i = 1'b1; tick();
        stb_i = 1'b0; spr_i = 1'b0;
        idle_clocks(140);
        check_int("R10", "cascade after strobe+start", int'(any_casc), 0);
        strobe("R10");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule